// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with Software-Forced Compare Events

This block is a sixteen-bit up-counter that advances on a timer-clock enable and feeds three output-compare channels. Each channel compares the count against its own sixteen-bit compare value. On a match it sets a sticky match flag and drives its waveform pin in one of four ways, selected by two bits per channel. Two counting behaviours are available. In free-running mode the counter wraps from 0xFFFF to 0. In clear-on-match mode, a match on channel 0 returns the counter to zero. Two further mode codes stand for pulse-width modes. In those codes the counter runs and the flags are set, but the pins are held and forcing is disabled.

Software reaches the block through a byte-wide register port. Sixteen-bit quantities pass through a single shared high-byte holding register, so that both halves move in one cycle. Reading a low byte captures the matching high byte for a later read. Writing a high byte parks it, and the following low-byte write commits all sixteen bits. A force register accepts one-cycle strobes that apply a channel's pin action at once, without a flag and without clearing the counter. A write to the counter suppresses every channel's compare on the next timer tick.

Top module: `timer16_fc`

## Requirements
- R1: After reset the counter, the compare values, the holding register, the mode, the pin-action settings and the flags read as zero, and all waveform pins are low.
- R2: The counter advances by one only in cycles where `tick` is high. It holds otherwise, and in mode 0 (free-running) it wraps from 0xFFFF to 0x0000.
- R3: Register map: address 0/1 is counter low/high, and addresses 2/3, 4/5 and 6/7 are the low/high bytes of compare channels 0, 1 and 2. Reading a low byte loads that word's high byte into the shared holding register. Reading any high-byte address returns the holding register. Writing a high-byte address loads the holding register, and writing a low byte stores {holding, data} into the word in that cycle.
- R4: When a tick occurs, the counter is not being written, no mask is pending and the count equals a channel's compare value, that channel's flag (bit k of address 11) is set. In modes 0 and 1, that channel's pin is also updated according to its action field in address 10, bits [2k+1:2k]: 01 toggles, 10 drives low, 11 drives high.
- R5: In mode 1 (clear-on-match; address 9 bits [1:0]), a match on channel 0 loads zero into the counter at that tick instead of incrementing.
- R6: In mode 0 or 1, writing address 8 with bit 7-k set applies channel k's pin action at that clock edge. The flags are unchanged and the counter is not cleared.
- R7: Address 8 always reads zero. In modes 2 and 3 a force write leaves the pins unchanged, and a match in those modes leaves the pins unchanged.
- R8: A counter low-byte write masks the compare on all channels for the next tick only. The tick after that compares normally.
- R9: Writing 1 to bit k of address 11 clears flag k, unless a match sets it in the same cycle. Writing 0 leaves the flag unchanged.
- R10: An action field of 00 leaves the channel's pin unchanged on both matches and forces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable; one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; has side effects on low-byte reads |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| wave | output | 3 | Waveform pins, bit k belongs to channel k |

## Verification
The `rdata` port is combinational. It is sampled 1 ns after the falling edge on which the address is driven, before the rising edge that applies the read's side effect to the holding register. Pins, flags and the counter change on the rising edge that samples a match, force or write, so they are compared from the next falling edge onward. The behavioural model steps on that same rising edge, and the pins are compared with it on every falling edge. The masking rule is observed by writing the counter to a compare value and checking that the flag stays clear after exactly one tick. It is set again one tick later.

// File: rtl/timer16_fc_pkg.sv
package timer16_fc_pkg;
  localparam int BYTE_W_D = 8;
  localparam int N_CH_D   = 3;
  localparam int ADDR_W_D = 4;

  // register addresses outside the word window
  localparam int A_CNT_LO = 0;
  localparam int A_FORCE  = 8;
  localparam int A_MODE   = 9;
  localparam int A_COM    = 10;
  localparam int A_FLAG   = 11;

  localparam logic [1:0] MD_FREE = 2'b00;
  localparam logic [1:0] MD_CTC  = 2'b01;

  localparam logic [1:0] ACT_KEEP   = 2'b00;
  localparam logic [1:0] ACT_TOGGLE = 2'b01;
  localparam logic [1:0] ACT_LOW    = 2'b10;
  localparam logic [1:0] ACT_HIGH   = 2'b11;

  // next pin level for a compare event under a given action
  function automatic logic pin_action(input logic cur, input logic [1:0] act);
    case (act)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

  function automatic logic mode_is_pwm(input logic [1:0] md);
    return md[1];
  endfunction
endpackage

// File: rtl/tfc_counter.sv
module tfc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ctc_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             blk
);
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic clr);
    return clr ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= cnt_step(cnt, ctc_clr);
      blk <= 1'b0;
    end
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !ctc_clr) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R2
  AST_LOAD_ARMS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> blk); // R8
endmodule

// File: rtl/tfc_channel.sv
module tfc_channel
  import timer16_fc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             blk,
  input  logic             load,
  input  logic             pwm,
  input  logic             frc_req,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ocr,
  input  logic [1:0]       act,
  output logic             match,
  output logic             flag,
  output logic             wave
);
  logic frc_evt;
  logic upd;

  assign match   = tick && !blk && !load && (cnt == ocr);
  assign frc_evt = frc_req && !pwm;
  assign upd     = (match && !pwm) || frc_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      wave <= 1'b0;
    end else begin
      if (upd) wave <= pin_action(wave, act);
      if (match) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R4
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && act == ACT_TOGGLE) |=> wave != $past(wave)); // R4
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_evt && !match) |=> !$rose(flag)); // R6
  AST_PWM_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |=> $stable(wave)); // R7
  AST_KEEP_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_KEEP) |=> $stable(wave)); // R10
endmodule

// File: rtl/tfc_regs.sv
module tfc_regs
  import timer16_fc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int N_CH   = 3,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic [2*BYTE_W-1:0]           cnt,
  input  logic [N_CH-1:0]               flags,
  output logic [BYTE_W-1:0]             rdata,
  output logic [N_CH-1:0][2*BYTE_W-1:0] ocr,
  output logic [N_CH-1:0][1:0]          act,
  output logic [1:0]                    mode,
  output logic                          cnt_load,
  output logic [2*BYTE_W-1:0]           cnt_val,
  output logic [N_CH-1:0]               frc_req,
  output logic [N_CH-1:0]               flag_clr
);
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int N_WORD    = N_CH + 1;
  localparam int WORD_SPAN = 2 * N_WORD;

  logic [BYTE_W-1:0] temp_q;
  logic [CNT_W-1:0]  words [N_WORD];
  logic [CNT_W-1:0]  sel_word;
  logic              in_words;
  logic              hi_sel;

  assign words[0] = cnt;
  for (genvar k = 0; k < N_CH; k++) begin : g_word
    assign words[k+1] = ocr[k];
  end

  assign in_words = int'(addr) < WORD_SPAN;
  assign hi_sel   = addr[0];

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < N_WORD; k++)
      if (int'(addr[ADDR_W-1:1]) == k) sel_word = words[k];
  end

  assign cnt_load = wr_en && (addr == ADDR_W'(A_CNT_LO));
  assign cnt_val  = {temp_q, wdata};

  for (genvar k = 0; k < N_CH; k++) begin : g_strobe
    assign frc_req[k]  = wr_en && (addr == ADDR_W'(A_FORCE)) && wdata[BYTE_W-1-k];
    assign flag_clr[k] = wr_en && (addr == ADDR_W'(A_FLAG)) && wdata[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      ocr    <= '0;
      act    <= '0;
      mode   <= '0;
    end else begin
      if (wr_en && in_words && hi_sel)
        temp_q <= wdata;
      else if (rd_en && !wr_en && in_words && !hi_sel)
        temp_q <= sel_word[CNT_W-1:BYTE_W];
      for (int k = 0; k < N_CH; k++)
        if (wr_en && (addr == ADDR_W'(2 * (k + 1))))
          ocr[k] <= {temp_q, wdata};
      if (wr_en && (addr == ADDR_W'(A_MODE)))
        mode <= wdata[1:0];
      if (wr_en && (addr == ADDR_W'(A_COM)))
        for (int k = 0; k < N_CH; k++)
          act[k] <= wdata[2*k +: 2];
    end
  end

  always_comb begin
    rdata = '0;
    if (in_words)
      rdata = hi_sel ? temp_q : sel_word[BYTE_W-1:0];
    else if (addr == ADDR_W'(A_MODE))
      rdata = BYTE_W'(mode);
    else if (addr == ADDR_W'(A_COM))
      rdata = BYTE_W'(act);
    else if (addr == ADDR_W'(A_FLAG))
      rdata = BYTE_W'(flags);
  end

  AST_LO_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADDR_W'(A_CNT_LO))
      |=> temp_q == $past(cnt[CNT_W-1:BYTE_W])); // R3
  AST_HI_WRITE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_words && hi_sel) |=> temp_q == $past(wdata)); // R3
  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_FORCE)) |-> rdata == '0); // R7
endmodule

// File: rtl/timer16_fc.sv
module timer16_fc
  import timer16_fc_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_D,
  parameter int N_CH   = N_CH_D,
  parameter int ADDR_W = ADDR_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [N_CH-1:0]   wave
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]            cnt;
  logic                        blk;
  logic [N_CH-1:0][CNT_W-1:0]  ocr;
  logic [N_CH-1:0][1:0]        act;
  logic [1:0]                  mode;
  logic                        cnt_load;
  logic [CNT_W-1:0]            cnt_val;
  logic [N_CH-1:0]             frc_req;
  logic [N_CH-1:0]             flag_clr;
  logic [N_CH-1:0]             flags;
  logic [N_CH-1:0]             match_vec;
  logic                        ctc;
  logic                        pwm;

  assign ctc = (mode == MD_CTC);
  assign pwm = mode_is_pwm(mode);

  tfc_regs #(.BYTE_W(BYTE_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .flags(flags), .rdata(rdata), .ocr(ocr),
    .act(act), .mode(mode), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .frc_req(frc_req), .flag_clr(flag_clr)
  );

  tfc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(cnt_val), .ctc_clr(ctc && match_vec[0]), .cnt(cnt), .blk(blk)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    tfc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .blk(blk), .load(cnt_load),
      .pwm(pwm), .frc_req(frc_req[k]), .flag_clr(flag_clr[k]), .cnt(cnt),
      .ocr(ocr[k]), .act(act[k]), .match(match_vec[k]), .flag(flags[k]),
      .wave(wave[k])
    );
  end

  AST_WRITE_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> match_vec == '0); // R8
  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && match_vec[0]) |=> cnt == '0); // R5
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctc && tick && !cnt_load && cnt == '1) |=> cnt == '0); // R2
  AST_FORCE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_req != '0 && !tick && !cnt_load) |=> $stable(cnt)); // R6
endmodule

// File: tb/timer16_fc_tb.sv
module timer16_fc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] wave;

  always #4 clk = ~clk;

  timer16_fc u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wave(wave)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_cnt, m_temp, m_mode, nt;
  int m_ocr[3], m_act[3], m_flag[3], m_wave[3];
  bit m_blk;
  bit mt[3], fv[3];

  function automatic int mword(int w);
    return (w == 0) ? m_cnt : m_ocr[w-1];
  endfunction

  function automatic int mrd(int a);
    if (a < 8) return (a % 2 == 1) ? m_temp : mword(a / 2) % 256;
    if (a == 9) return m_mode;
    if (a == 10) return m_act[0] + 4 * m_act[1] + 16 * m_act[2];
    if (a == 11) return m_flag[0] + 2 * m_flag[1] + 4 * m_flag[2];
    return 0;
  endfunction

  function automatic int mwave();
    return m_wave[0] + 2 * m_wave[1] + 4 * m_wave[2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_temp = 0; m_mode = 0; m_blk = 0;
      for (int i = 0; i < 3; i++) begin
        m_ocr[i] = 0; m_act[i] = 0; m_flag[i] = 0; m_wave[i] = 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        mt[i] = tick && !(wr_en && addr == 0) && !m_blk && (m_cnt == m_ocr[i]);
        fv[i] = wr_en && addr == 8 && wdata[7-i] && m_mode < 2;
      end
      nt = m_temp;
      if (wr_en && addr < 8 && addr[0]) nt = wdata;
      else if (rd_en && !wr_en && addr < 8 && !addr[0]) nt = mword(addr / 2) / 256;
      for (int i = 0; i < 3; i++) begin
        if (m_mode < 2 && (mt[i] || fv[i])) begin
          if (m_act[i] == 1) m_wave[i] = 1 - m_wave[i];
          else if (m_act[i] == 2) m_wave[i] = 0;
          else if (m_act[i] == 3) m_wave[i] = 1;
        end
        if (mt[i]) m_flag[i] = 1;
        else if (wr_en && addr == 11 && wdata[i]) m_flag[i] = 0;
      end
      if (wr_en && addr == 0) begin
        m_cnt = m_temp * 256 + wdata; m_blk = 1;
      end else if (tick) begin
        m_cnt = (m_mode == 1 && mt[0]) ? 0 : (m_cnt + 1) % 65536;
        m_blk = 0;
      end
      if (wr_en && (addr == 2 || addr == 4 || addr == 6))
        m_ocr[addr/2 - 1] = m_temp * 256 + wdata;
      if (wr_en && addr == 9) m_mode = wdata % 4;
      if (wr_en && addr == 10)
        for (int i = 0; i < 3; i++) m_act[i] = (wdata >> (2 * i)) % 4;
      m_temp = nt;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // pins compared with the model on every falling edge (R4, R6, R7, R10)
  always @(negedge clk)
    if (rst_n && !done) chk(int'(wave) == mwave(), "R4 pins", wave, mwave());

  task automatic wr(input int a, input int d);
    tick = 1'b0; wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string rq);
    tick = 1'b0; rd_en = 1'b1; addr = 4'(a);
    #1 chk(int'(rdata) == mrd(a), rq, rdata, mrd(a));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rdx(input int a, input string rq, input int exp);
    tick = 1'b0; rd_en = 1'b1; addr = 4'(a);
    #1;
    chk(int'(rdata) == mrd(a), rq, rdata, mrd(a));
    chk(int'(rdata) == exp, rq, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      tick = rnd ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything reads zero after reset
    for (int a = 0; a < 12; a++) rdx(a, "R1", 0);
    chk(wave == 3'b000, "R1 pins", wave, 0);
    // actions: ch0 toggle, ch1 low, ch2 high; compares 5, 3, 10
    wr(10, 8'h39);
    wr(3, 0); wr(2, 5);
    wr(5, 0); wr(4, 3);
    wr(7, 0); wr(6, 10);
    rdx(4, "R3", 3); rdx(5, "R3", 0);
    run(12, 1'b0);
    rdx(0, "R2", 12);
    rdx(11, "R4", 7);
    chk(wave == 3'b101, "R4 pins", wave, 5);
    wr(11, 8'h02);
    rdx(11, "R9", 5);
    run(40, 1'b1);
    rd(0, "R3"); rd(1, "R3");
    // R6: force in free-running mode
    wr(8, 8'hE0);
    chk(wave == 3'b100, "R6 pins", wave, 4);
    rdx(11, "R6", 5);
    // R5: clear-on-match with channel 0 compare 7
    wr(9, 1); wr(1, 0); wr(0, 0);
    wr(3, 0); wr(2, 7);
    run(30, 1'b0);
    rdx(0, "R5", 6);
    wr(8, 8'h80);
    rdx(0, "R6", 6);
    // R7: pulse-width codes ignore force, force reads zero
    wr(9, 2);
    w0 = int'(wave);
    wr(8, 8'hE0);
    chk(int'(wave) == w0, "R7 pins", wave, w0);
    rdx(8, "R7", 0);
    run(20, 1'b0);
    chk(int'(wave) == w0, "R7 pins", wave, w0);
    // R8: counter write masks next tick only
    wr(9, 0); wr(11, 7);
    rdx(11, "R9", 0);
    wr(1, 0); wr(0, 3);
    run(1, 1'b0);
    rdx(11, "R8", 0);
    rdx(0, "R8", 4);
    wr(1, 0); wr(0, 2);
    run(2, 1'b0);
    rdx(11, "R8", 2);
    // R2: wrap from 0xFFFF
    wr(1, 8'hFF); wr(0, 8'hFE);
    run(3, 1'b0);
    rdx(0, "R2", 1); rdx(1, "R2", 0);
    // R10: action 00 leaves pins alone
    wr(10, 0);
    w0 = int'(wave);
    wr(8, 8'hE0);
    chk(int'(wave) == w0, "R10 pins", wave, w0);
    wr(1, 0); wr(0, 0);
    run(16, 1'b0);
    chk(int'(wave) == w0, "R10 pins", wave, w0);
    run(30, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL timeout R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule